// File: doc/BRIEF.md
# Page-mode pseudo-SRAM controller

This block sits between a synchronous host and an asynchronous pseudo-SRAM of 1M words by 16 bits. It turns host requests into the memory's strobe sequences. The strobes are chip select, output enable, write enable, two active-low byte-lane enables and power-down. It also drives a 20-bit word address and a data bus that is split into out, in and output-enable signals. Each timing minimum of the memory is a parameter that gives a whole number of clock cycles.

A host request carries a start address, a word count of one to four, a byte-lane mask and, for writes, up to four data words. The controller always opens with a precharge gap and then a full random-access cycle. Further words in the same four-word page follow as short in-page cycles while chip select stays low. A burst that would run past a page boundary is closed and reopened with a new random cycle. The same happens when the next in-page cycle would stretch chip select beyond its budget. Read words come back one per pulse on a response port.

Top module: `psram_page_ctrl`

## Requirements
- R1: After reset the controller holds chip select, output enable and write enable high, keeps the data bus released and keeps `req_ready` low for exactly `T_PWRUP` clock cycles. In the cycle after that it accepts requests.
- R2: While chip select stays low, only address bits [1:0] change. The word after one at address bits [1:0] = 3 always starts a new chip-select stretch.
- R3: In a read, the first address of a stretch is held for `T_RC` cycles and each later in-page address for `T_PAA` cycles. The returned word is the bus value in the last cycle of that address.
- R4: Chip select stays high for at least `T_PRE` cycles between two low stretches, and every accepted request begins with such a gap.
- R5: In a write, write enable is low for the whole stretch. The first address is held `T_RC` cycles and each later in-page address `T_PWC` cycles. Each word is written when the address changes or when chip select rises.
- R6: `req_be` bit 1 enables the upper byte (bus bits 15:8) and bit 0 the lower byte (bits 7:0). A disabled lane is not written, and it reads back as zero in `rsp_data`.
- R7: The controller drives the data bus only while chip select and write enable are both low.
- R8: A chip-select low stretch never lasts more than `CS_MAX` cycles. A burst that would exceed it goes on after a precharge gap with a new random cycle.
- R9: The bus output enable and the memory output enable are never active together. The bus output enable is low in the cycle before the memory output enable falls.
- R10: `req_ready` is high only when idle, and a request is taken on `req_valid` and `req_ready`. `req_len` + 1 words are handled at consecutive addresses, with word i of `req_wdata` at bits [16i+15:16i]. A read gives exactly that many `rsp_valid` pulses, in address order.
- R11: Power-down (`mem_pd_n`) stays high at all times, so the memory is never put to sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address of the first word |
| req_len | input | 2 | Word count minus one |
| req_be | input | 2 | Byte-lane mask, bit 1 upper, bit 0 lower |
| req_wdata | input | 64 | Up to four write words, word i at [16i+15:16i] |
| rsp_valid | output | 1 | One pulse per read word |
| rsp_data | output | 16 | Read word, disabled lanes zero |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_bl_n | output | 2 | Byte-lane enables, active low, bit 1 upper |
| mem_pd_n | output | 1 | Power-down, active low, held high |
| mem_addr | output | 20 | Memory word address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
A wrong sequencer state shows up on the strobes within one access. An address held for the wrong number of cycles breaks R3 or R5 as soon as the address changes or chip select rises. A wrong page decision or budget decision shows at once as a stretch that crosses a page or runs too long. An error in the data path shows when the word is read back, or on the next `rsp_valid` pulse with a wrong lane or wrong order. A wrong turnaround shows in the very cycle it happens, because the bus output enable and the memory output enable overlap.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int ADDR_W_DEF    = 20;
    localparam int DATA_W_DEF    = 16;
    localparam int PAGE_BITS_DEF = 2;

    typedef enum logic [2:0] {
        ST_PWRUP = 3'd0,
        ST_IDLE  = 3'd1,
        ST_PRE   = 3'd2,
        ST_FIRST = 3'd3,
        ST_PAGE  = 3'd4
    } ctl_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_timer.sv
module psram_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rst_val,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= rst_val;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/psram_cs_guard.sv
module psram_cs_guard #(
    parameter int CS_MAX = 1600,
    parameter int W      = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_acc,
    input  logic [W-1:0] next_cost,
    output logic         room_ok,
    output logic [W-1:0] run
);
    logic [W:0] need;

    always_ff @(posedge clk) begin
        if (rst || !in_acc) begin
            run <= '0;
        end else begin
            run <= run + W'(1);
        end
    end

    // cycles low after the current access ends plus one more in-page access
    assign need    = {1'b0, run} + {1'b0, next_cost} + (W+1)'(1);
    assign room_ok = (need <= (W+1)'(CS_MAX));

    // R8: the low stretch never exceeds its budget
    p_cs_stretch_r8: assert property (@(posedge clk) disable iff (rst)
        in_acc |-> (run < W'(CS_MAX)));
endmodule

// File: rtl/psram_lane_path.sv
module psram_lane_path #(
    parameter int DATA_W = 16,
    parameter int BURST  = 4,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [BURST*DATA_W-1:0] wdata,
    input  logic                    step,
    input  logic                    cap,
    input  logic [LANES-1:0]        be,
    input  logic [DATA_W-1:0]       dq_in,
    output logic [DATA_W-1:0]       dq_out,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_data
);
    logic [DATA_W-1:0] wbuf [BURST];
    logic [DATA_W-1:0] masked;

    always_ff @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < BURST; i++) begin
                wbuf[i] <= wdata[i*DATA_W +: DATA_W];
            end
        end else if (step) begin
            for (int i = 0; i < BURST-1; i++) begin
                wbuf[i] <= wbuf[i+1];
            end
        end
    end

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            assign masked[l*8 +: 8] = be[l] ? dq_in[l*8 +: 8] : 8'h00;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cap;
            if (cap) begin
                rsp_data <= masked;
            end
        end
    end

    assign dq_out = wbuf[0];

    // R6: a disabled lane returns zero
    p_lane_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (cap && !be[0]) |=> (rsp_data[7:0] == 8'h00));
endmodule

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int DATA_W    = DATA_W_DEF,
    parameter int PAGE_BITS = PAGE_BITS_DEF,
    parameter int T_PWRUP   = 10000,
    parameter int T_RC      = 7,
    parameter int T_PAA     = 4,
    parameter int T_PWC     = 4,
    parameter int T_PRE     = 1,
    parameter int CS_MAX    = 1600
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic                                  req_write,
    input  logic [ADDR_W-1:0]                     req_addr,
    input  logic [PAGE_BITS-1:0]                  req_len,
    input  logic [DATA_W/8-1:0]                   req_be,
    input  logic [(1<<PAGE_BITS)*DATA_W-1:0]      req_wdata,
    output logic                                  rsp_valid,
    output logic [DATA_W-1:0]                     rsp_data,
    output logic                                  mem_cs_n,
    output logic                                  mem_oe_n,
    output logic                                  mem_we_n,
    output logic [DATA_W/8-1:0]                   mem_bl_n,
    output logic                                  mem_pd_n,
    output logic [ADDR_W-1:0]                     mem_addr,
    output logic [DATA_W-1:0]                     mem_dq_out,
    output logic                                  mem_dq_oe,
    input  logic [DATA_W-1:0]                     mem_dq_in
);
    localparam int BURST  = 1 << PAGE_BITS;
    localparam int LANES  = DATA_W / 8;
    localparam int TMAX   = max2(max2(T_PWRUP, T_RC), max2(max2(T_PAA, T_PWC), T_PRE));
    localparam int CNT_W  = $clog2(TMAX + 1);
    localparam int RUN_W  = $clog2(max2(CS_MAX, max2(T_PAA, T_PWC)) + 1) + 1;

    ctl_state_e           state, nxt;
    logic [ADDR_W-1:0]    addr_q;
    logic                 wr_q;
    logic [LANES-1:0]     be_q;
    logic [PAGE_BITS:0]   left_q;

    logic                 accept, step, cap, in_acc, last_in_page;
    logic                 tmr_load, tmr_zero, room_ok;
    logic [CNT_W-1:0]     tmr_val;
    logic [RUN_W-1:0]     next_cost, cs_run;

    assign accept       = (state == ST_IDLE) && req_valid;
    assign in_acc       = (state == ST_FIRST) || (state == ST_PAGE);
    assign last_in_page = (addr_q[PAGE_BITS-1:0] == '1);
    assign next_cost    = wr_q ? RUN_W'(T_PWC) : RUN_W'(T_PAA);

    psram_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .rst_val  (CNT_W'(T_PWRUP - 1)),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    psram_cs_guard #(.CS_MAX(CS_MAX), .W(RUN_W)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .in_acc    (in_acc),
        .next_cost (next_cost),
        .room_ok   (room_ok),
        .run       (cs_run)
    );

    psram_lane_path #(.DATA_W(DATA_W), .BURST(BURST), .LANES(LANES)) u_lanes (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .wdata     (req_wdata),
        .step      (step),
        .cap       (cap),
        .be        (be_q),
        .dq_in     (mem_dq_in),
        .dq_out    (mem_dq_out),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        step     = 1'b0;
        cap      = 1'b0;
        case (state)
            ST_PWRUP: begin
                if (tmr_zero) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    nxt      = ST_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_PRE - 1);
                end
            end
            ST_PRE: begin
                if (tmr_zero) begin
                    nxt      = ST_FIRST;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_RC - 1);
                end
            end
            ST_FIRST, ST_PAGE: begin
                if (tmr_zero) begin
                    cap  = !wr_q;
                    step = 1'b1;
                    if (left_q == (PAGE_BITS+1)'(1)) begin
                        nxt = ST_IDLE;
                    end else if (last_in_page || !room_ok) begin
                        nxt      = ST_PRE;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_PRE - 1);
                    end else begin
                        nxt      = ST_PAGE;
                        tmr_load = 1'b1;
                        tmr_val  = wr_q ? CNT_W'(T_PWC - 1) : CNT_W'(T_PAA - 1);
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_PWRUP;
            addr_q <= '0;
            wr_q   <= 1'b0;
            be_q   <= '0;
            left_q <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                addr_q <= req_addr;
                wr_q   <= req_write;
                be_q   <= req_be;
                left_q <= {1'b0, req_len} + (PAGE_BITS+1)'(1);
            end else if (step) begin
                addr_q <= addr_q + ADDR_W'(1);
                left_q <= left_q - (PAGE_BITS+1)'(1);
            end
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign mem_cs_n  = !in_acc;
    assign mem_oe_n  = !(in_acc && !wr_q);
    assign mem_we_n  = !(in_acc && wr_q);
    assign mem_bl_n  = in_acc ? ~be_q : '1;
    assign mem_pd_n  = 1'b1;
    assign mem_addr  = addr_q;
    assign mem_dq_oe = in_acc && wr_q;

    // R1: nothing happens on the memory side during the power-up wait
    p_pwrup_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PWRUP) |-> (mem_cs_n && !req_ready && !mem_dq_oe));

    // R2: only the in-page bits may move while chip select is held low
    p_page_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |->
        (mem_addr[ADDR_W-1:PAGE_BITS] == $past(mem_addr[ADDR_W-1:PAGE_BITS])));

    // R7: the bus is released whenever chip select is high
    p_bus_idle_r7: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n |-> !mem_dq_oe);

    // R9: never both sides driving
    p_no_fight_r9: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    // R9: the bus is already released when the memory is told to drive
    p_turnaround_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    // R10: a response only follows a read cycle
    p_rsp_read_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !$past(mem_oe_n));
endmodule

// File: tb/psram_page_ctrl_bench.sv
module psram_page_ctrl_bench;
    localparam int CLK_P   = 10;
    localparam int T_PWRUP = 20;
    localparam int T_RC    = 7;
    localparam int T_PAA   = 4;
    localparam int T_PWC   = 3;
    localparam int T_PRE   = 2;
    localparam int CS_MAX  = 14;

    typedef struct packed {
        logic        wr;
        logic [19:0] addr;
        logic [1:0]  lm1;
        logic [1:0]  be;
        logic [15:0] seed;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 20'd0,  2'd3, 2'b11, 16'h1000},
        '{1'b0, 20'd0,  2'd3, 2'b11, 16'h0000},
        '{1'b1, 20'd6,  2'd2, 2'b11, 16'h2000},
        '{1'b0, 20'd5,  2'd3, 2'b11, 16'h0000},
        '{1'b1, 20'd9,  2'd0, 2'b10, 16'h3C77},
        '{1'b1, 20'd10, 2'd0, 2'b01, 16'h55AB},
        '{1'b0, 20'd8,  2'd3, 2'b11, 16'h0000},
        '{1'b0, 20'd8,  2'd1, 2'b01, 16'h0000},
        '{1'b0, 20'd8,  2'd1, 2'b10, 16'h0000},
        '{1'b1, 20'd3,  2'd0, 2'b11, 16'hBEEF},
        '{1'b0, 20'd3,  2'd0, 2'b11, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_len = '0;
    logic [1:0]  req_be = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_pd_n, mem_dq_oe;
    logic [1:0]  mem_bl_n;
    logic [19:0] mem_addr;
    logic [15:0] mem_dq_out, mem_dq_in;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    psram_page_ctrl #(
        .T_PWRUP(T_PWRUP), .T_RC(T_RC), .T_PAA(T_PAA), .T_PWC(T_PWC),
        .T_PRE(T_PRE), .CS_MAX(CS_MAX)
    ) u_psram_page_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_bl_n(mem_bl_n), .mem_pd_n(mem_pd_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // memory model: word written when address moves or write strobes end
    logic [15:0] marr [64];
    logic        pw_act = 1'b0;
    logic [19:0] pw_addr = '0;
    logic [15:0] pw_data = '0;
    logic [1:0]  pw_bl = 2'b11;

    initial for (int i = 0; i < 64; i++) marr[i] = 16'h0000;

    always_comb begin
        if (!mem_cs_n && !mem_oe_n)
            mem_dq_in = {mem_bl_n[1] ? 8'h00 : marr[mem_addr[5:0]][15:8],
                         mem_bl_n[0] ? 8'h00 : marr[mem_addr[5:0]][7:0]};
        else
            mem_dq_in = 16'h0000;
    end

    always @(negedge clk) begin
        logic wact;
        wact = !mem_cs_n && !mem_we_n;
        if (pw_act && (!wact || mem_addr != pw_addr)) begin
            if (!pw_bl[0]) marr[pw_addr[5:0]][7:0]  = pw_data[7:0];
            if (!pw_bl[1]) marr[pw_addr[5:0]][15:8] = pw_data[15:8];
        end
        pw_act  = wact;
        pw_addr = mem_addr;
        pw_data = mem_dq_oe ? mem_dq_out : 16'hDEAD;
        pw_bl   = mem_bl_n;
    end

    // response collector
    logic [15:0] rsp_buf [8];
    int rsp_cnt = 0;
    always @(negedge clk) begin
        if (rsp_valid) begin
            if (rsp_cnt < 8) rsp_buf[rsp_cnt] = rsp_data;
            rsp_cnt++;
        end
    end

    // strobe timing monitor
    logic mon_en = 1'b0;
    logic p_cl = 1'b0;
    logic [19:0] p_addr = '0;
    logic seen = 1'b0;
    logic seg_first = 1'b0;
    logic seg_wr = 1'b0;
    int gap = 0;
    int stretch = 0;
    int seg = 0;

    task automatic end_seg();
        int exp;
        exp = seg_first ? T_RC : (seg_wr ? T_PWC : T_PAA);
        if (seg_wr) chk("R5 write address hold", seg, exp);
        else        chk("R3 read address hold", seg, exp);
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (!mem_cs_n) begin
                if (!p_cl) begin
                    if (seen) chk("R4 precharge gap", 32'(gap >= T_PRE), 1);
                    seen = 1'b1;
                    stretch = 1;
                    seg = 1;
                    seg_first = 1'b1;
                end else begin
                    stretch++;
                    if (mem_addr == p_addr) seg++;
                    else begin
                        end_seg();
                        chk("R2 page held in stretch", 32'(mem_addr[19:2]), 32'(p_addr[19:2]));
                        seg = 1;
                        seg_first = 1'b0;
                    end
                end
                seg_wr = !mem_we_n;
                chk("R8 stretch budget", 32'(stretch <= CS_MAX), 1);
                if (mem_we_n) chk("R7 bus released in read", 32'(mem_dq_oe), 0);
            end else begin
                if (p_cl) begin
                    end_seg();
                    gap = 1;
                end else gap++;
                chk("R7 bus released when deselected", 32'(mem_dq_oe), 0);
            end
            chk("R11 power-down high", 32'(mem_pd_n), 1);
            p_cl = !mem_cs_n;
            p_addr = mem_addr;
        end
    end

    // bench shadow of the memory contents
    logic [15:0] sh [64];
    initial for (int i = 0; i < 64; i++) sh[i] = 16'h0000;

    task automatic run_op(input vec_t v);
        logic [63:0] wd;
        int idx;
        logic [15:0] w, e;
        for (int i = 0; i < 4; i++) wd[16*i +: 16] = v.seed + 16'(i) * 16'h0101;
        while (!req_ready) @(negedge clk);
        rsp_cnt   = 0;
        req_valid = 1'b1;
        req_write = v.wr;
        req_addr  = v.addr;
        req_len   = v.lm1;
        req_be    = v.be;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 ready low while busy", 32'(req_ready), 0);
        while (!req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        for (int i = 0; i <= int'(v.lm1); i++) begin
            idx = int'((v.addr + 20'(i)) & 20'h3F);
            if (v.wr) begin
                w = wd[16*i +: 16];
                if (v.be[0]) sh[idx][7:0]  = w[7:0];
                if (v.be[1]) sh[idx][15:8] = w[15:8];
            end
        end
        if (!v.wr) begin
            chk("R10 response count", rsp_cnt, int'(v.lm1) + 1);
            for (int i = 0; i <= int'(v.lm1); i++) begin
                idx = int'((v.addr + 20'(i)) & 20'h3F);
                e = {v.be[1] ? sh[idx][15:8] : 8'h00, v.be[0] ? sh[idx][7:0] : 8'h00};
                chk("R6 R3 read data", 32'(rsp_buf[i]), 32'(e));
            end
        end else begin
            chk("R10 no response on write", rsp_cnt, 0);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R10 act=hang exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cs high in reset", 32'(mem_cs_n), 1);
        chk("R1 oe high in reset", 32'(mem_oe_n), 1);
        chk("R1 we high in reset", 32'(mem_we_n), 1);
        chk("R1 bus released in reset", 32'(mem_dq_oe), 0);
        chk("R1 not ready in reset", 32'(req_ready), 0);
        chk("R11 power-down high in reset", 32'(mem_pd_n), 1);
        rst = 1'b0;
        mon_en = 1'b1;
        // R1: request held off while the power-up wait runs, even with valid high
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = 20'd0;
        repeat (T_PWRUP - 1) @(negedge clk);
        chk("R1 not ready before wait ends", 32'(req_ready), 0);
        chk("R1 cs high during wait", 32'(mem_cs_n), 1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1 ready when wait ends", 32'(req_ready), 1);
        repeat (2) @(negedge clk);
        chk("R10 idle stays deselected", 32'(mem_cs_n), 1);

        for (int k = 0; k < NV; k++) run_op(VECS[k]);

        // corner: read across the top of the address space wraps to word 0
        run_op('{1'b0, 20'hFFFFE, 2'd3, 2'b11, 16'h0000});

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule